// File: doc/BRIEF.md
# Dual-Converter Simultaneous Conversion Coordinator

This block drives two conversion engines, a master and a slave, so that both walk through their channel lists in lockstep from one shared trigger. Each engine is reached through a plain handshake: a one-cycle start pulse with a channel number, answered some cycles later by a one-cycle done pulse carrying a 12-bit result. The block picks the trigger for each of its two groups from a bank of eight trigger lines, launches both engines in the same cycle, and moves to the next rank only when both have answered.

Two groups share the engines. The priority group is at most four ranks long and keeps every result in a per-engine, per-rank register. The normal group is at most sixteen ranks long and packs each result pair into one 32-bit word, offered through a request and acknowledge pair for a DMA engine. Each group raises an end-of-sequence pulse once the last pair of both engines is in. The block refuses a sequence in which the two engines would sample the same channel in the same rank. It records lost triggers and lost DMA words in one sticky overrun flag.

Top module: `dsc_dual_coord`

## Requirements
- R1: Trigger line `trig_in[hp_sel]` starts the priority group and `trig_in[nr_sel]` starts the normal group. Pulses on any other trigger line have no effect.
- R2: When the engines are free, `m_start` and `s_start` pulse together for one cycle, beginning two clock edges after the edge that samples the trigger. `m_chan` and `s_chan` carry the current rank's entry of the running group's master and slave lists.
- R3: A new start is issued only after both engines have returned done for the current rank. The engines may answer after different delays.
- R4: On each completed priority-group pair, the master result goes to `hp_m_res[12r+11:12r]` and the slave result goes to `hp_s_res[12r+11:12r]`, where r is the rank.
- R5: `hp_irq` pulses for one cycle, one edge after the last pair of the priority sequence completes, if `hp_ie_m` or `hp_ie_s` is set. It stays low if neither is set.
- R6: Each completed normal-group pair loads `dma_word` with the slave result in bits 31:16 and the master result in bits 15:0, both zero-extended. If `dma_en` is set, `dma_req` also rises and stays high until the edge that samples `dma_ack`.
- R7: `nr_irq` pulses for one cycle after the last normal-group pair completes, if `nr_ie_m` or `nr_ie_s` is set.
- R8: `hp_len` and `nr_len` hold the number of ranks minus one. Rank r's channel sits at bits [5r+4:5r] of each list. Each engine steps through its own list, in whatever order that list holds.
- R9: `cfg_err` is high while, for some rank r up to the programmed length of either group, the master and slave lists hold the same channel. A trigger for an affected group then starts nothing and is not counted as an overrun.
- R10: A trigger for a group whose sequence is still running is ignored and sets the sticky `ovr`. `ovr_clr` clears `ovr`.
- R11: If a normal pair completes while `dma_req` is still unacknowledged, the new word replaces the old one, `dma_req` stays high and `ovr` is set.
- R12: The priority group takes the engines at the next rank boundary ahead of a pending normal rank. A normal sequence in progress resumes afterwards without losing a rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_in | input | 8 | Trigger lines, one-cycle pulses |
| hp_sel | input | 3 | Trigger line index for the priority group |
| nr_sel | input | 3 | Trigger line index for the normal group |
| hp_len | input | 2 | Priority-group rank count minus one |
| nr_len | input | 4 | Normal-group rank count minus one |
| hp_m_chans | input | 20 | Master channel per priority rank |
| hp_s_chans | input | 20 | Slave channel per priority rank |
| nr_m_chans | input | 80 | Master channel per normal rank |
| nr_s_chans | input | 80 | Slave channel per normal rank |
| hp_ie_m | input | 1 | Priority end interrupt enable, master side |
| hp_ie_s | input | 1 | Priority end interrupt enable, slave side |
| nr_ie_m | input | 1 | Normal end interrupt enable, master side |
| nr_ie_s | input | 1 | Normal end interrupt enable, slave side |
| dma_en | input | 1 | Enables DMA requests for normal pairs |
| dma_ack | input | 1 | DMA acknowledge |
| ovr_clr | input | 1 | Clears the overrun flag |
| m_start | output | 1 | Master engine start |
| m_chan | output | 5 | Master engine channel |
| m_done | input | 1 | Master engine done |
| m_data | input | 12 | Master engine result |
| s_start | output | 1 | Slave engine start |
| s_chan | output | 5 | Slave engine channel |
| s_done | input | 1 | Slave engine done |
| s_data | input | 12 | Slave engine result |
| hp_m_res | output | 48 | Master priority results, 12 bits per rank |
| hp_s_res | output | 48 | Slave priority results, 12 bits per rank |
| dma_word | output | 32 | Packed normal pair |
| dma_req | output | 1 | DMA request |
| hp_irq | output | 1 | Priority end-of-sequence pulse |
| nr_irq | output | 1 | Normal end-of-sequence pulse |
| cfg_err | output | 1 | Same channel in the same rank on both engines |
| ovr | output | 1 | Sticky overrun |

## Verification
The start pulses appear two edges after the edge that samples a trigger. Results, the packed word with its request, and the end-of-sequence pulses appear one edge after the later of the two done pulses. The next rank starts two edges after that done edge. The bench drives every input and samples every output on the falling edge, so each of these delays lands on a whole number of falling edges. The trigger-to-start delay is checked at exactly the second falling edge. Longer results are checked only after the end pulse they depend on has been seen. The bench's engine models flag any start that arrives while either engine is still converting.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int CH_W     = 5;
  localparam int DW       = 12;
  localparam int HP_RANKS = 4;
  localparam int NR_RANKS = 16;
  localparam int TRIG_N   = 8;
  localparam int LIST_W   = NR_RANKS * CH_W;
  localparam int LAST_W   = $clog2(NR_RANKS);

  // slave half above, master half below
  function automatic logic [31:0] pack_pair(input logic [15:0] slv, input logic [15:0] mst);
    return {slv, mst};
  endfunction

  // true when any rank up to 'last' samples one channel on both engines
  function automatic logic lists_clash(input logic [LIST_W-1:0] ml,
                                       input logic [LIST_W-1:0] sl,
                                       input logic [LAST_W-1:0] last);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < NR_RANKS; r++)
      if (r <= int'(last) && ml[r*CH_W +: CH_W] == sl[r*CH_W +: CH_W]) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/dsc_trig_mux.sv
module dsc_trig_mux #(
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  trig_in,
  input  logic [SW-1:0] sel,
  output logic          pulse
);
  assign pulse = trig_in[sel];
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq #(
  parameter int RANKS = 4,
  localparam int LW = $clog2(RANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [LW-1:0] last,
  input  logic          cfg_ok,
  input  logic          gnt,
  input  logic          pair_done,
  output logic          busy,
  output logic          req,
  output logic [LW-1:0] rank,
  output logic          seq_done,
  output logic          trig_lost
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rank <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (trig && cfg_ok) begin
          st   <= S_REQ;
          rank <= '0;
        end
        S_REQ: if (gnt) st <= S_WAIT;
        S_WAIT: if (pair_done) begin
          if (rank == last) st <= S_IDLE;
          else begin
            rank <= rank + 1'b1;
            st   <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign req       = (st == S_REQ);
  assign seq_done  = (st == S_WAIT) && pair_done && (rank == last);
  assign trig_lost = trig && busy;

  // R9: a refused trigger leaves the sequencer idle
  p_refuse_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && trig && !cfg_ok) |=> (st == S_IDLE));

  // R3: without a completed pair the rank holds
  p_hold_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !pair_done) |=> (st == S_WAIT && $stable(rank)));

  // R8: rank never passes the programmed length
  p_rank_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rank <= last));
endmodule

// File: rtl/dsc_pair_collect.sv
module dsc_pair_collect #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          m_done,
  input  logic [DW-1:0] m_data,
  input  logic          s_done,
  input  logic [DW-1:0] s_data,
  output logic          eng_busy,
  output logic          pair_fire,
  output logic [DW-1:0] m_res,
  output logic [DW-1:0] s_res
);
  logic          m_got, s_got;
  logic [DW-1:0] m_q, s_q;
  logic          m_have, s_have;

  assign m_have    = m_got || (eng_busy && m_done);
  assign s_have    = s_got || (eng_busy && s_done);
  assign pair_fire = eng_busy && m_have && s_have;
  assign m_res     = m_got ? m_q : m_data;
  assign s_res     = s_got ? s_q : s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0;
      m_got    <= 1'b0;
      s_got    <= 1'b0;
      m_q      <= '0;
      s_q      <= '0;
    end else if (launch) begin
      eng_busy <= 1'b1;
      m_got    <= 1'b0;
      s_got    <= 1'b0;
    end else if (pair_fire) begin
      eng_busy <= 1'b0;
      m_got    <= 1'b0;
      s_got    <= 1'b0;
    end else begin
      if (eng_busy && m_done && !m_got) begin
        m_got <= 1'b1;
        m_q   <= m_data;
      end
      if (eng_busy && s_done && !s_got) begin
        s_got <= 1'b1;
        s_q   <= s_data;
      end
    end
  end

  // R3: the arbiter launches only onto free engines
  p_launch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !eng_busy);

  // R3: a completed pair frees the engines
  p_fire_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> !eng_busy);
endmodule

// File: rtl/dsc_dual_coord.sv
module dsc_dual_coord
  import dsc_pkg::*;
#(
  parameter int TRIG_N   = dsc_pkg::TRIG_N,
  parameter int CH_W     = dsc_pkg::CH_W,
  parameter int DW       = dsc_pkg::DW,
  parameter int HP_RANKS = dsc_pkg::HP_RANKS,
  parameter int NR_RANKS = dsc_pkg::NR_RANKS,
  localparam int SEL_W = $clog2(TRIG_N),
  localparam int HP_LW = $clog2(HP_RANKS),
  localparam int NR_LW = $clog2(NR_RANKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TRIG_N-1:0]        trig_in,
  input  logic [SEL_W-1:0]         hp_sel,
  input  logic [SEL_W-1:0]         nr_sel,
  input  logic [HP_LW-1:0]         hp_len,
  input  logic [NR_LW-1:0]         nr_len,
  input  logic [HP_RANKS*CH_W-1:0] hp_m_chans,
  input  logic [HP_RANKS*CH_W-1:0] hp_s_chans,
  input  logic [NR_RANKS*CH_W-1:0] nr_m_chans,
  input  logic [NR_RANKS*CH_W-1:0] nr_s_chans,
  input  logic                     hp_ie_m,
  input  logic                     hp_ie_s,
  input  logic                     nr_ie_m,
  input  logic                     nr_ie_s,
  input  logic                     dma_en,
  input  logic                     dma_ack,
  input  logic                     ovr_clr,
  output logic                     m_start,
  output logic [CH_W-1:0]          m_chan,
  input  logic                     m_done,
  input  logic [DW-1:0]            m_data,
  output logic                     s_start,
  output logic [CH_W-1:0]          s_chan,
  input  logic                     s_done,
  input  logic [DW-1:0]            s_data,
  output logic [HP_RANKS*DW-1:0]   hp_m_res,
  output logic [HP_RANKS*DW-1:0]   hp_s_res,
  output logic [31:0]              dma_word,
  output logic                     dma_req,
  output logic                     hp_irq,
  output logic                     nr_irq,
  output logic                     cfg_err,
  output logic                     ovr
);
  // named internal events
  logic             hp_trig, nr_trig;
  logic             hp_clash, nr_clash;
  logic             hp_busy, nr_busy, hp_req, nr_req;
  logic [HP_LW-1:0] hp_rank;
  logic [NR_LW-1:0] nr_rank;
  logic             hp_done_ev, nr_done_ev, hp_lost, nr_lost;
  logic             hp_gnt, nr_gnt, launch;
  logic             eng_busy, pair_fire, owner_hp;
  logic             hp_pair, nr_pair, dma_ovr;
  logic [DW-1:0]    m_res, s_res;

  dsc_trig_mux #(.N(TRIG_N)) u_hp_mux (.trig_in(trig_in), .sel(hp_sel), .pulse(hp_trig));
  dsc_trig_mux #(.N(TRIG_N)) u_nr_mux (.trig_in(trig_in), .sel(nr_sel), .pulse(nr_trig));

  assign hp_clash = lists_clash(LIST_W'(hp_m_chans), LIST_W'(hp_s_chans), LAST_W'(hp_len));
  assign nr_clash = lists_clash(LIST_W'(nr_m_chans), LIST_W'(nr_s_chans), LAST_W'(nr_len));
  assign cfg_err  = hp_clash || nr_clash;

  // priority group wins free engines
  assign hp_gnt  = hp_req && !eng_busy;
  assign nr_gnt  = nr_req && !eng_busy && !hp_req;
  assign launch  = hp_gnt || nr_gnt;
  assign hp_pair = pair_fire && owner_hp;
  assign nr_pair = pair_fire && !owner_hp;

  dsc_seq #(.RANKS(HP_RANKS)) u_hp_seq (
    .clk(clk), .rst_n(rst_n), .trig(hp_trig), .last(hp_len), .cfg_ok(!hp_clash),
    .gnt(hp_gnt), .pair_done(hp_pair), .busy(hp_busy), .req(hp_req), .rank(hp_rank),
    .seq_done(hp_done_ev), .trig_lost(hp_lost));

  dsc_seq #(.RANKS(NR_RANKS)) u_nr_seq (
    .clk(clk), .rst_n(rst_n), .trig(nr_trig), .last(nr_len), .cfg_ok(!nr_clash),
    .gnt(nr_gnt), .pair_done(nr_pair), .busy(nr_busy), .req(nr_req), .rank(nr_rank),
    .seq_done(nr_done_ev), .trig_lost(nr_lost));

  dsc_pair_collect #(.DW(DW)) u_collect (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .m_done(m_done), .m_data(m_data), .s_done(s_done), .s_data(s_data),
    .eng_busy(eng_busy), .pair_fire(pair_fire), .m_res(m_res), .s_res(s_res));

  // engine launch, both sides in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start  <= 1'b0;
      s_start  <= 1'b0;
      m_chan   <= '0;
      s_chan   <= '0;
      owner_hp <= 1'b0;
    end else begin
      m_start <= launch;
      s_start <= launch;
      if (launch) begin
        owner_hp <= hp_gnt;
        m_chan   <= hp_gnt ? hp_m_chans[hp_rank*CH_W +: CH_W] : nr_m_chans[nr_rank*CH_W +: CH_W];
        s_chan   <= hp_gnt ? hp_s_chans[hp_rank*CH_W +: CH_W] : nr_s_chans[nr_rank*CH_W +: CH_W];
      end
    end
  end

  // priority-group result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_m_res <= '0;
      hp_s_res <= '0;
    end else if (hp_pair) begin
      hp_m_res[hp_rank*DW +: DW] <= m_res;
      hp_s_res[hp_rank*DW +: DW] <= s_res;
    end
  end

  // packed word and DMA request
  assign dma_ovr = nr_pair && dma_en && dma_req && !dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_word <= '0;
      dma_req  <= 1'b0;
    end else begin
      if (nr_pair) dma_word <= pack_pair(16'(s_res), 16'(m_res));
      if (nr_pair && dma_en) dma_req <= 1'b1;
      else if (dma_ack)      dma_req <= 1'b0;
    end
  end

  // end pulses and sticky overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_irq <= 1'b0;
      nr_irq <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      hp_irq <= hp_done_ev && (hp_ie_m || hp_ie_s);
      nr_irq <= nr_done_ev && (nr_ie_m || nr_ie_s);
      ovr    <= (ovr && !ovr_clr) || hp_lost || nr_lost || dma_ovr;
    end
  end

  // R2: a start pulse marks freshly launched engines
  p_start_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_start |-> (eng_busy && !$past(eng_busy)));

  // R5: the priority end pulse comes with both engines free
  p_hp_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |-> !eng_busy);

  // R7: the normal end pulse comes with both engines free
  p_nr_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nr_irq |-> !eng_busy);

  // R6: an unacknowledged request holds
  p_dma_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);

  // R12: with both groups waiting the priority group owns the engines next
  p_hp_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_req && nr_req && !eng_busy) |=> owner_hp);

  // R10: a lost trigger leaves the overrun flag set
  p_lost_sets_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_lost || nr_lost) |=> ovr);
endmodule

// File: tb/sim_dsc_dual_coord.sv
`timescale 1ns/1ps
module sim_dsc_dual_coord;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  trig_in = '0;
  logic [2:0]  hp_sel = 3'd3, nr_sel = 3'd5;
  logic [1:0]  hp_len = '0;
  logic [3:0]  nr_len = '0;
  logic [19:0] hp_m_chans = '0, hp_s_chans = '0;
  logic [79:0] nr_m_chans = '0, nr_s_chans = '0;
  logic        hp_ie_m = 1'b1, hp_ie_s = 1'b0, nr_ie_m = 1'b1, nr_ie_s = 1'b0;
  logic        dma_en = 1'b1, dma_ack = 1'b0, ovr_clr = 1'b0;
  logic        m_start, s_start, m_done = 1'b0, s_done = 1'b0;
  logic [4:0]  m_chan, s_chan;
  logic [11:0] m_data = '0, s_data = '0;
  logic [47:0] hp_m_res, hp_s_res;
  logic [31:0] dma_word;
  logic        dma_req, hp_irq, nr_irq, cfg_err, ovr;

  dsc_dual_coord u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .hp_sel(hp_sel), .nr_sel(nr_sel),
    .hp_len(hp_len), .nr_len(nr_len), .hp_m_chans(hp_m_chans), .hp_s_chans(hp_s_chans),
    .nr_m_chans(nr_m_chans), .nr_s_chans(nr_s_chans), .hp_ie_m(hp_ie_m), .hp_ie_s(hp_ie_s),
    .nr_ie_m(nr_ie_m), .nr_ie_s(nr_ie_s), .dma_en(dma_en), .dma_ack(dma_ack), .ovr_clr(ovr_clr),
    .m_start(m_start), .m_chan(m_chan), .m_done(m_done), .m_data(m_data),
    .s_start(s_start), .s_chan(s_chan), .s_done(s_done), .s_data(s_data),
    .hp_m_res(hp_m_res), .hp_s_res(hp_s_res), .dma_word(dma_word), .dma_req(dma_req),
    .hp_irq(hp_irq), .nr_irq(nr_irq), .cfg_err(cfg_err), .ovr(ovr));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  logic [5:0] round = '0;
  function automatic logic [11:0] dat(input bit side, input logic [4:0] ch);
    return {side, round, ch};
  endfunction

  function automatic logic [31:0] word_of(input int r);
    logic [31:0] hi, lo;
    hi = 32'(dat(1'b1, nr_s_chans[r*5 +: 5])) << 16;
    lo = 32'(dat(1'b0, nr_m_chans[r*5 +: 5]));
    return hi | lo;
  endfunction

  // engine models, start log and R3 overlap check
  int m_cnt = 0, s_cnt = 0, log_n = 0;
  logic [4:0] m_cap, s_cap;
  logic [4:0] log_m [256];
  logic [4:0] log_s [256];
  always @(negedge clk) begin
    m_done = 1'b0;
    s_done = 1'b0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_done = 1'b1; m_data = dat(1'b0, m_cap); end
    end
    if (s_cnt > 0) begin
      s_cnt--;
      if (s_cnt == 0) begin s_done = 1'b1; s_data = dat(1'b1, s_cap); end
    end
    if (m_start || s_start) begin
      chk(m_start === 1'b1 && s_start === 1'b1, "R2", "lockstep start",
          {30'd0, m_start, s_start}, 32'd3);
      if (m_cnt > 0 || s_cnt > 0) chk(1'b0, "R3", "start while converting", m_cnt, 0);
      m_cap = m_chan;
      s_cap = s_chan;
      m_cnt = 1 + int'($urandom % 5);
      s_cnt = 1 + int'($urandom % 5);
      if (log_n < 256) begin log_m[log_n] = m_chan; log_s[log_n] = s_chan; end
      log_n++;
    end
  end

  // DMA monitor and end-pulse counters
  bit ack_mode = 1'b1, man_ack = 1'b0;
  int dma_idx = 0, hp_cnt = 0, nr_cnt = 0, hp_at = 0, nr_at = 0;
  logic [31:0] exp_w [16];
  always @(negedge clk) begin
    dma_ack = 1'b0;
    if (ack_mode && dma_req) begin
      chk(dma_idx < 16 && dma_word == exp_w[dma_idx[3:0]], "R6", "packed word",
          dma_word, exp_w[dma_idx[3:0]]);
      dma_idx++;
      dma_ack = 1'b1;
    end else if (man_ack) begin
      dma_ack = 1'b1;
      man_ack = 1'b0;
    end
    if (hp_irq) begin hp_cnt++; hp_at = cyc; end
    if (nr_irq) begin nr_cnt++; nr_at = cyc; end
  end

  task automatic pulse(input int idx);
    trig_in[idx] = 1'b1;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_nr(input int len, input bit mirror);
    round++;
    nr_len = 4'(len);
    for (int r = 0; r < 16; r++) begin
      logic [4:0] a, b;
      if (mirror) begin a = 5'(r); b = 5'(15 - r); end
      else begin
        a = 5'($urandom % 18);
        b = 5'((int'(a) + 1 + int'($urandom % 17)) % 18);
      end
      nr_m_chans[r*5 +: 5] = a;
      nr_s_chans[r*5 +: 5] = b;
    end
    for (int r = 0; r < 16; r++) exp_w[r] = word_of(r);
    dma_idx = 0;
    log_n = 0;
  endtask

  task automatic set_hp(input int len);
    hp_len = 2'(len);
    for (int r = 0; r < 4; r++) begin
      logic [4:0] a;
      a = 5'($urandom % 18);
      hp_m_chans[r*5 +: 5] = a;
      hp_s_chans[r*5 +: 5] = 5'((int'(a) + 1 + int'($urandom % 17)) % 18);
    end
  endtask

  task automatic wait_nr(input int prev);
    for (int i = 0; i < 400 && nr_cnt == prev; i++) @(negedge clk);
    idle(3);
  endtask

  task automatic check_hp(input int len);
    for (int r = 0; r <= len; r++) begin
      chk(hp_m_res[r*12 +: 12] == dat(1'b0, hp_m_chans[r*5 +: 5]), "R4", "master rank result",
          32'(hp_m_res[r*12 +: 12]), 32'(dat(1'b0, hp_m_chans[r*5 +: 5])));
      chk(hp_s_res[r*12 +: 12] == dat(1'b1, hp_s_chans[r*5 +: 5]), "R4", "slave rank result",
          32'(hp_s_res[r*12 +: 12]), 32'(dat(1'b1, hp_s_chans[r*5 +: 5])));
    end
  endtask

  task automatic run_nr(input int len, input bit mirror);
    int prev;
    set_nr(len, mirror);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    wait_nr(prev);
    chk(dma_idx == len + 1, "R6", "word count", dma_idx, len + 1);
    chk(nr_cnt == prev + 1, "R7", "normal end pulse", nr_cnt, prev + 1);
    chk(log_n == len + 1, "R8", "rank count", log_n, len + 1);
    for (int r = 0; r <= len; r++)
      chk(log_m[r] == nr_m_chans[r*5 +: 5] && log_s[r] == nr_s_chans[r*5 +: 5], "R8",
          "channel order", {log_m[r], log_s[r]}, {nr_m_chans[r*5 +: 5], nr_s_chans[r*5 +: 5]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int prev;
    void'($urandom(32'd1957));
    set_nr(0, 1'b1);
    set_hp(0);
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    chk(!m_start && !s_start && !dma_req && !hp_irq && !nr_irq && !ovr && !cfg_err && dma_word == 0,
        "R6", "reset outputs", {m_start, s_start, dma_req, hp_irq, nr_irq, ovr, cfg_err}, 0);

    // R2: trigger-to-start timing, exact falling edge
    set_nr(3, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    chk(m_start == 1'b0, "R2", "no start one edge after trigger", m_start, 0);
    @(negedge clk);
    chk(m_start && s_start && m_chan == nr_m_chans[4:0] && s_chan == nr_s_chans[4:0], "R2",
        "start with rank 0 channels", {m_start, s_start, m_chan, s_chan},
        {2'b11, nr_m_chans[4:0], nr_s_chans[4:0]});
    wait_nr(prev);
    chk(dma_idx == 4, "R6", "words after directed run", dma_idx, 4);

    // R1: other trigger lines do nothing
    log_n = 0;
    for (int t = 0; t < 8; t++) if (t != int'(nr_sel) && t != int'(hp_sel)) pulse(t);
    idle(10);
    chk(log_n == 0 && !ovr, "R1", "unselected lines ignored", log_n, 0);

    // random normal runs, R1 with moving select
    for (int k = 0; k < 6; k++) begin
      nr_sel = 3'($urandom % 8);
      hp_sel = nr_sel + 3'd1 + 3'($urandom % 7);
      run_nr(int'($urandom % 16), k == 2);
    end
    run_nr(15, 1'b1);

    // R4 and R5: random priority runs with enable mixes
    for (int k = 0; k < 6; k++) begin
      bit em, es;
      int len;
      em = k[0]; es = k[1];
      hp_ie_m = em; hp_ie_s = es;
      len = int'($urandom % 4);
      round++;
      set_hp(len);
      log_n = 0;
      prev = hp_cnt;
      pulse(int'(hp_sel));
      idle(60);
      check_hp(len);
      chk(hp_cnt == prev + ((em || es) ? 1 : 0), "R5", "priority end pulse vs enables",
          hp_cnt - prev, (em || es) ? 1 : 0);
      chk(log_n == len + 1, "R8", "priority rank count", log_n, len + 1);
    end
    hp_ie_m = 1'b1;

    // R7 via slave-side enable only
    nr_ie_m = 1'b0; nr_ie_s = 1'b1;
    run_nr(2, 1'b0);
    nr_ie_s = 1'b0;
    set_nr(1, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    idle(40);
    chk(nr_cnt == prev && dma_idx == 2, "R7", "no end pulse with enables off", nr_cnt - prev, 0);
    nr_ie_m = 1'b1;

    // R9: clash within length refuses, clash beyond length is fine
    set_nr(4, 1'b0);
    nr_s_chans[3*5 +: 5] = nr_m_chans[3*5 +: 5];
    idle(1);
    chk(cfg_err == 1'b1, "R9", "clash flagged", cfg_err, 1);
    pulse(int'(nr_sel));
    idle(20);
    chk(log_n == 0 && !ovr, "R9", "refused start, no overrun", {log_n[30:0], ovr}, 0);
    nr_len = 4'd2;
    idle(1);
    chk(cfg_err == 1'b0, "R9", "clash past length ignored", cfg_err, 0);

    // R10: trigger during a running normal sequence
    set_nr(7, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    idle(6);
    pulse(int'(nr_sel));
    chk(ovr == 1'b1, "R10", "lost trigger sets overrun", ovr, 1);
    wait_nr(prev);
    chk(dma_idx == 8 && log_n == 8 && nr_cnt == prev + 1, "R10", "sequence not restarted",
        dma_idx, 8);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr == 1'b0, "R10", "overrun cleared", ovr, 0);

    // R11: unacknowledged words overwritten
    ack_mode = 1'b0;
    set_nr(2, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    wait_nr(prev);
    chk(dma_req && dma_word == word_of(2), "R11", "last word kept", dma_word, word_of(2));
    chk(ovr == 1'b1, "R11", "dma overrun flagged", ovr, 1);
    man_ack = 1'b1;
    idle(2);
    chk(dma_req == 1'b0, "R6", "request dropped after ack", dma_req, 0);
    ack_mode = 1'b1;
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;

    // R6: requests off, word still packed
    dma_en = 1'b0;
    set_nr(1, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    wait_nr(prev);
    chk(!dma_req && dma_idx == 0 && dma_word == word_of(1), "R6", "no request when disabled",
        dma_word, word_of(1));
    dma_en = 1'b1;

    // R12: priority run cuts into a long normal run
    round++;
    set_hp(3);
    set_nr(15, 1'b0);
    prev = nr_cnt;
    pulse(int'(nr_sel));
    idle(12);
    pulse(int'(hp_sel));
    wait_nr(prev);
    chk(hp_at > 0 && hp_at < nr_at, "R12", "priority ends first", hp_at, nr_at);
    chk(log_n == 20 && dma_idx == 16, "R12", "no normal rank lost", dma_idx, 16);
    check_hp(3);
    chk(!ovr, "R12", "no overrun from interleave", ovr, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule